// File: doc/BRIEF.md
# Dual-Bank Zero-Fill Engine

After power-up the two data memory banks of a signal processor hold arbitrary values. This engine clears both banks before any program uses them. Software, or a boot sequencer, gives a length in quad-words (groups of `LANES` words) and pulses a start input. From then on the engine writes zero words into both banks in the same cycle, `LANES` consecutive words per bank per clock. It stops by itself once the count is used up. The default geometry is four lanes and 8192 words per bank, so a full clear takes 2048 cycles.

The engine has one base address counter, which advances by `LANES` on every working cycle. Lane `i` of each bank writes to `base + i`. A busy flag covers the working cycles. A sticky done flag reports that the work has finished and stays set until the next accepted start. A length larger than one bank holds is clipped to a full bank, so the address counter never wraps onto words it has already written.

Top module: `zfill_engine`

## Requirements
- R1: While reset is held (rst_n low), and in the first cycle after it, busy_o and done_o are 0 and every write enable of both banks is 0.
- R2: A start_i seen at a clock edge while busy_o is 0, with a nonzero length, makes busy_o 1 and done_o 0 from that edge on.
- R3: In every cycle with busy_o at 1, all `LANES` write enables of both banks are 1, every write data lane is zero, and both banks present the same addresses.
- R4: Lane i writes word address base+i. The base is 0 in the first busy cycle and grows by `LANES` in each following busy cycle.
- R5: busy_o stays 1 for exactly the accepted length in cycles. At the edge where it falls, done_o rises, and no write follows.
- R6: done_o, once 1, stays 1 until the next accepted start.
- R7: A start_i while busy_o is 1 is ignored: the address sequence, the length and the finishing cycle are unchanged.
- R8: A start with length 0 leaves busy_o at 0 and sets done_o at the next edge, with no write to either bank.
- R9: A length above 2^ADDR_W / LANES quad-words is clipped to that value, so each bank is cleared exactly once.
- R10: When busy_o is 0, every write enable of both banks is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled at each rising edge |
| len_i | input | LEN_W | Fill length in quad-words, captured with the start |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | Fill finished, held until the next start |
| b0_we_o | output | LANES | Bank 0 write enable per lane |
| b0_addr_o | output | LANES*ADDR_W | Bank 0 word address per lane, lane 0 in the low bits |
| b0_wdata_o | output | LANES*DATA_W | Bank 0 write data per lane (zero) |
| b1_we_o | output | LANES | Bank 1 write enable per lane |
| b1_addr_o | output | LANES*ADDR_W | Bank 1 word address per lane, lane 0 in the low bits |
| b1_wdata_o | output | LANES*DATA_W | Bank 1 write data per lane (zero) |

## Verification
The bench builds the engine with ADDR_W=6, DATA_W=8 and LANES=4. Each bank is then 64 words, or 16 quad-words, and LEN_W is 5. With these values a complete clear of a bank fits in a few cycles, and lengths from 17 to 31 can be driven, which reaches the clipping boundary and the wrap of the base counter after a full bank. The small banks are also modelled word by word, so the bench can confirm that every word below the fill limit turns to zero and every word above it keeps its prior value.

// File: rtl/zfill_pkg.sv
package zfill_pkg;

   typedef enum logic [0:0] {
      ZF_IDLE = 1'b0,
      ZF_RUN  = 1'b1
   } zf_state_t;

   localparam int ZF_NUM_BANKS = 2;

   function automatic bit zf_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/zfill_ctrl.sv
module zfill_ctrl
   import zfill_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int LANES  = 4,
   localparam int LANE_BITS = $clog2(LANES),
   localparam int LEN_W     = ADDR_W - LANE_BITS + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             accept_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam logic [LEN_W-1:0] CAP_QUADS = LEN_W'(1) << (ADDR_W - LANE_BITS);

   zf_state_t        state_q;
   logic [LEN_W-1:0] remain_q;
   logic [LEN_W-1:0] eff_len;
   logic             done_q;

   assign accept_o = start_i && (state_q == ZF_IDLE);
   assign eff_len  = (len_i > CAP_QUADS) ? CAP_QUADS : len_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ZF_IDLE;
         remain_q <= '0;
         done_q   <= 1'b0;
      end else if (accept_o) begin
         if (eff_len == '0) begin
            state_q <= ZF_IDLE;
            done_q  <= 1'b1;
         end else begin
            state_q  <= ZF_RUN;
            remain_q <= eff_len;
            done_q   <= 1'b0;
         end
      end else if (state_q == ZF_RUN) begin
         remain_q <= remain_q - 1'b1;
         if (remain_q == LEN_W'(1)) begin
            state_q <= ZF_IDLE;
            done_q  <= 1'b1;
         end
      end
   end

   assign busy_o = (state_q == ZF_RUN);
   assign done_o = done_q;

endmodule

// File: rtl/zfill_addr_gen.sv
module zfill_addr_gen #(
   parameter int ADDR_W = 13,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] base_o
);

   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LANES);

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (clear_i) begin
         base_q <= '0;
      end else if (step_i) begin
         base_q <= base_q + STRIDE;
      end
   end

   assign base_o = base_q;

endmodule

// File: rtl/zfill_bank_port.sv
module zfill_bank_port #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic                     busy_i,
   input  logic [ADDR_W-1:0]        base_i,
   output logic [LANES-1:0]         we_o,
   output logic [LANES*ADDR_W-1:0]  addr_o,
   output logic [LANES*DATA_W-1:0]  wdata_o
);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign we_o[ln]                      = busy_i;
      assign addr_o[ln*ADDR_W +: ADDR_W]   = base_i + ADDR_W'(ln);
      assign wdata_o[ln*DATA_W +: DATA_W]  = '0;
   end

endmodule

// File: rtl/zfill_engine.sv
module zfill_engine
   import zfill_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   localparam int LANE_BITS = $clog2(LANES),
   localparam int LEN_W     = ADDR_W - LANE_BITS + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [LEN_W-1:0]        len_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic [LANES-1:0]        b0_we_o,
   output logic [LANES*ADDR_W-1:0] b0_addr_o,
   output logic [LANES*DATA_W-1:0] b0_wdata_o,
   output logic [LANES-1:0]        b1_we_o,
   output logic [LANES*ADDR_W-1:0] b1_addr_o,
   output logic [LANES*DATA_W-1:0] b1_wdata_o
);

   if (!zf_is_pow2(LANES)) begin : g_bad_lanes
      $error("zfill_engine: LANES must be a power of two");
   end
   if (ADDR_W <= LANE_BITS) begin : g_bad_addr
      $error("zfill_engine: ADDR_W must exceed log2(LANES)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("zfill_engine: DATA_W must be positive");
   end

   logic              accept;
   logic              busy;
   logic [ADDR_W-1:0] base;

   logic [LANES-1:0]        we_arr    [ZF_NUM_BANKS];
   logic [LANES*ADDR_W-1:0] addr_arr  [ZF_NUM_BANKS];
   logic [LANES*DATA_W-1:0] wdata_arr [ZF_NUM_BANKS];

   zfill_ctrl #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .len_i    (len_i),
      .accept_o (accept),
      .busy_o   (busy),
      .done_o   (done_o)
   );

   zfill_addr_gen #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .step_i  (busy),
      .base_o  (base)
   );

   for (genvar bk = 0; bk < ZF_NUM_BANKS; bk++) begin : g_bank
      zfill_bank_port #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .LANES  (LANES)
      ) u_port (
         .busy_i  (busy),
         .base_i  (base),
         .we_o    (we_arr[bk]),
         .addr_o  (addr_arr[bk]),
         .wdata_o (wdata_arr[bk])
      );
   end

   assign busy_o     = busy;
   assign b0_we_o    = we_arr[0];
   assign b0_addr_o  = addr_arr[0];
   assign b0_wdata_o = wdata_arr[0];
   assign b1_we_o    = we_arr[1];
   assign b1_addr_o  = addr_arr[1];
   assign b1_wdata_o = wdata_arr[1];

endmodule

// File: rtl/zfill_chk.sv
module zfill_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   localparam int LANE_BITS = $clog2(LANES),
   localparam int LEN_W     = ADDR_W - LANE_BITS + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [LEN_W-1:0]        len_i,
   input logic                    busy_o,
   input logic                    done_o,
   input logic [LANES-1:0]        b0_we_o,
   input logic [LANES*ADDR_W-1:0] b0_addr_o,
   input logic [LANES*DATA_W-1:0] b0_wdata_o,
   input logic [LANES-1:0]        b1_we_o,
   input logic [LANES*ADDR_W-1:0] b1_addr_o,
   input logic [LANES*DATA_W-1:0] b1_wdata_o
);

   logic [ADDR_W-1:0] lane0;
   assign lane0 = b0_addr_o[ADDR_W-1:0];

   // R10
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (b0_we_o == '0) && (b1_we_o == '0));

   // R3
   busy_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (&b0_we_o) && (&b1_we_o) && (b0_wdata_o == '0)
                 && (b1_wdata_o == '0) && (b0_addr_o == b1_addr_o));

   // R4
   base_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> lane0 == ADDR_W'($past(lane0) + ADDR_W'(LANES)));

   // R2
   start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && (len_i != '0) |=> busy_o && !done_o);

   // R8
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && (len_i == '0) |=> !busy_o && done_o);

   // R5
   finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o);

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> lane0 != '0);

endmodule

bind zfill_engine zfill_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANES  (LANES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .len_i      (len_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .b0_we_o    (b0_we_o),
   .b0_addr_o  (b0_addr_o),
   .b0_wdata_o (b0_wdata_o),
   .b1_we_o    (b1_we_o),
   .b1_addr_o  (b1_addr_o),
   .b1_wdata_o (b1_wdata_o)
);

// File: tb/zfill_engine_bench.sv
module zfill_engine_bench;

   localparam int ADDR_W = 6;
   localparam int DATA_W = 8;
   localparam int LANES  = 4;
   localparam int LEN_W  = ADDR_W - 2 + 1;
   localparam int WORDS  = 1 << ADDR_W;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    start_i = 1'b0;
   logic [LEN_W-1:0]        len_i = '0;
   logic                    busy_o, done_o;
   logic [LANES-1:0]        b0_we_o, b1_we_o;
   logic [LANES*ADDR_W-1:0] b0_addr_o, b1_addr_o;
   logic [LANES*DATA_W-1:0] b0_wdata_o, b1_wdata_o;

   always #5 clk = ~clk;

   zfill_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_zfill_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .len_i      (len_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .b0_we_o    (b0_we_o),
      .b0_addr_o  (b0_addr_o),
      .b0_wdata_o (b0_wdata_o),
      .b1_we_o    (b1_we_o),
      .b1_addr_o  (b1_addr_o),
      .b1_wdata_o (b1_wdata_o)
   );

   int total = 0;
   int bad   = 0;
   int busy_cnt = 0;
   int exp_q[$];
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Memory model, one writer process
   logic             reload = 1'b0;
   logic [DATA_W-1:0] mem0 [WORDS];
   logic [DATA_W-1:0] mem1 [WORDS];

   function automatic logic [DATA_W-1:0] pat(input int i);
      return DATA_W'(8'h80 | i);
   endfunction

   always @(posedge clk) begin
      if (reload) begin
         for (int i = 0; i < WORDS; i++) begin
            mem0[i] <= pat(i);
            mem1[i] <= pat(i);
         end
      end else begin
         for (int ln = 0; ln < LANES; ln++) begin
            if (b0_we_o[ln]) mem0[b0_addr_o[ln*ADDR_W +: ADDR_W]] <= b0_wdata_o[ln*DATA_W +: DATA_W];
            if (b1_we_o[ln]) mem1[b1_addr_o[ln*ADDR_W +: ADDR_W]] <= b1_wdata_o[ln*DATA_W +: DATA_W];
         end
      end
   end

   // Monitor: pops one expected base per write cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o) busy_cnt++;
         if ((b0_we_o != '0) || (b1_we_o != '0)) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected write", int'(b0_we_o | b1_we_o), 0);
            end else begin
               int base;
               bit ok;
               base = exp_q.pop_front();
               ok = (b0_we_o == '1) && (b1_we_o == '1);
               check(ok, "R3", "lane enables", int'({b1_we_o, b0_we_o}), 255);
               for (int ln = 0; ln < LANES; ln++) begin
                  int a0, a1;
                  a0 = int'(b0_addr_o[ln*ADDR_W +: ADDR_W]);
                  a1 = int'(b1_addr_o[ln*ADDR_W +: ADDR_W]);
                  check(a0 == base + ln, "R4", "bank0 lane addr", a0, base + ln);
                  check(a1 == base + ln, "R4", "bank1 lane addr", a1, base + ln);
               end
               check((b0_wdata_o == '0) && (b1_wdata_o == '0), "R3", "write data zero",
                     int'(b0_wdata_o | b1_wdata_o), 0);
            end
         end
      end
   end

   task automatic do_reload();
      @(negedge clk) reload = 1'b1;
      @(negedge clk) reload = 1'b0;
   endtask

   task automatic check_mem(input int eff, input string req);
      int bad0, bad1;
      bad0 = -1; bad1 = -1;
      for (int i = WORDS - 1; i >= 0; i--) begin
         logic [DATA_W-1:0] e;
         e = (i < eff * LANES) ? '0 : pat(i);
         if (mem0[i] !== e) bad0 = i;
         if (mem1[i] !== e) bad1 = i;
      end
      check(bad0 < 0, req, "bank0 contents, first bad word", bad0, -1);
      check(bad1 < 0, req, "bank1 contents, first bad word", bad1, -1);
   endtask

   // Driver: pushes expected bases, pulses start, waits for done
   task automatic fill(input int len, input int eff, input int poke_at, input string req);
      int waited;
      for (int k = 0; k < eff; k++) exp_q.push_back(k * LANES);
      @(negedge clk);
      busy_cnt = 0;
      start_i = 1'b1;
      len_i   = LEN_W'(len);
      @(negedge clk);
      start_i = 1'b0;
      // R2 / R8: state one edge after the start
      check(busy_o == (eff > 0), "R2", "busy after start", int'(busy_o), int'(eff > 0));
      check(done_o == (eff == 0), "R8", "done after start", int'(done_o), int'(eff == 0));
      if (poke_at > 0) begin
         repeat (poke_at - 1) @(negedge clk);
         // R7: second start during busy
         start_i = 1'b1;
         len_i   = LEN_W'(1);
         @(negedge clk);
         start_i = 1'b0;
      end
      waited = 0;
      while (!done_o && waited < 100) begin
         @(negedge clk);
         waited++;
      end
      check(done_o == 1'b1, req, "done after fill", int'(done_o), 1);
      check(busy_o == 1'b0, "R5", "busy after done", int'(busy_o), 0);
      check(busy_cnt == eff, req, "busy cycles", busy_cnt, eff);
      check(exp_q.size() == 0, "R4", "leftover expected writes", exp_q.size(), 0);
      repeat (3) @(negedge clk);
      // R6: done held while idle
      check(done_o == 1'b1, "R6", "done held", int'(done_o), 1);
      check(exp_q.size() == 0 && b0_we_o == '0, "R10", "no write after done",
            int'(b0_we_o), 0);
      check_mem(eff, req);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      reload = 1'b1;
      repeat (3) @(negedge clk);
      // R1: during reset
      check(!busy_o && !done_o && b0_we_o == '0 && b1_we_o == '0, "R1", "reset state",
            int'({busy_o, done_o}), 0);
      reload = 1'b0;
      rst_n  = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && b0_we_o == '0 && b1_we_o == '0, "R1", "after reset",
            int'({busy_o, done_o}), 0);

      fill(3, 3, 0, "R5");
      do_reload();
      fill(16, 16, 0, "R5");
      do_reload();
      fill(0, 0, 0, "R8");
      do_reload();
      fill(2, 2, 0, "R6");
      do_reload();
      fill(20, 16, 0, "R9");
      do_reload();
      fill(31, 16, 0, "R9");
      do_reload();
      fill(8, 8, 3, "R7");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule